// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is a target on an open-drain two-wire serial bus (I2C-compatible framing) that gives a bus controller read and write access to a byte-wide configuration space of 256 addresses. It watches the SCL and SDA lines, recognises START, repeated START and STOP, answers to one 7-bit device address, and acknowledges each byte it receives by pulling SDA low in the ninth clock of that byte.

A write frame carries a register pointer byte followed by any number of data bytes, which land at consecutive addresses. Reads come in three flavours that all use one shared pointer: a current-address read continues from where the last access left off, a random read loads the pointer in a write frame and turns around with a repeated START, and a sequential read keeps streaming while the controller acknowledges. The pointer wraps from FFh to 00h. Only two address windows are backed by flip-flops; their contents drive the rest of the chip through two flat image buses and return to fixed defaults on reset.

Top module: `twi_cfg_target`

## Requirements
- R1: The target answers only to device address 47h; a frame with any other address gets no acknowledge and changes no register.
- R2: For every byte the target receives in an addressed frame (address byte with R/W=0, pointer byte, data bytes), SDA is low on the ninth SCL clock.
- R3: In a write frame the first byte after the device address loads the pointer; each following data byte is stored at the pointer, which then advances by one, until STOP.
- R4: The pointer wraps from FFh to 00h when it advances.
- R5: A read frame without a preceding pointer byte returns the byte at one past the last location read or written.
- R6: A repeated START after the pointer byte ends the write with no data stored, and the following read starts at that pointer.
- R7: During a read the target sends successive locations while the controller acknowledges; a not-acknowledge then STOP ends the transfer and the target releases SDA.
- R8: Only addresses 0Ah–17h and 40h–57h hold storage; writes elsewhere are acknowledged and discarded, reads elsewhere return 00h.
- R9: Reset loads 88h at 16h, 5Fh at 17h, BFh at 41h, A0h at 43h and 00h in every other backed register.
- R10: `win_a_o` bits [8i+7:8i] carry register 0Ah+i and `win_b_o` bits [8i+7:8i] carry register 40h+i, updated the cycle after the write.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| win_a_o | output | 112 | Image of registers 0Ah–17h, one byte each |
| win_b_o | output | 192 | Image of registers 40h–57h, one byte each |

## Verification
The hardest situation to reach is the pointer rolling over from FFh into the unbacked low addresses and then back into storage, since no single access lands there. The stimulus loads the pointer with FFh in a write frame, turns around with a repeated START and reads twelve bytes in one acknowledged run, so the last byte comes from 0Ah and only matches if the wrap and the unbacked zeros both behave. Bit-level transfers are driven through an open-drain bus model, so every acknowledge and data bit is sampled at the pins while SCL is high.

// File: rtl/twi_cfg_pkg.sv
package twi_cfg_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_ADDR,
        PS_REG,
        PS_WDAT,
        PS_SACK,
        PS_RDAT,
        PS_MACK,
        PS_WAIT
    } proto_st_e;

    typedef struct packed {
        proto_st_e   st;
        proto_st_e   nxt;
        logic [3:0]  bits;
        logic [7:0]  sh;
        logic [7:0]  ptr;
        logic        macked;
        logic        oe;
    } proto_s;

    // power-on contents of the backed registers
    function automatic logic [7:0] reg_default(input logic [7:0] a);
        case (a)
            8'h16:   return 8'h88;
            8'h17:   return 8'h5F;
            8'h41:   return 8'hBF;
            8'h43:   return 8'hA0;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/twi_pin_sync.sv
module twi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh_d, scl_sh_q;
    logic [STAGES-1:0] sda_sh_d, sda_sh_q;
    logic              scl_last_d, scl_last_q;
    logic              sda_last_d, sda_last_q;
    logic              scl_s;

    assign scl_s = scl_sh_q[STAGES-1];
    assign sda_s = sda_sh_q[STAGES-1];

    always_comb begin
        scl_sh_d   = {scl_sh_q[STAGES-2:0], scl_i};
        sda_sh_d   = {sda_sh_q[STAGES-2:0], sda_i};
        scl_last_d = scl_s;
        sda_last_d = sda_s;
        scl_rise   = scl_s & ~scl_last_q;
        scl_fall   = ~scl_s & scl_last_q;
        start_det  = scl_s & scl_last_q & sda_last_q & ~sda_s;
        stop_det   = scl_s & scl_last_q & ~sda_last_q & sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q   <= '1;
            sda_sh_q   <= '1;
            scl_last_q <= 1'b1;
            sda_last_q <= 1'b1;
        end else begin
            scl_sh_q   <= scl_sh_d;
            sda_sh_q   <= sda_sh_d;
            scl_last_q <= scl_last_d;
            sda_last_q <= sda_last_d;
        end
    end
endmodule

// File: rtl/twi_reg_window.sv
module twi_reg_window
    import twi_cfg_pkg::*;
#(
    parameter int BASE = 10,
    parameter int LEN  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    output logic             hit,
    output logic [7:0]       rdata,
    output logic [LEN*8-1:0] image
);
    logic [7:0] regs_d [LEN];
    logic [7:0] regs_q [LEN];

    always_comb begin
        hit   = 1'b0;
        rdata = 8'h00;
        for (int i = 0; i < LEN; i++) begin
            regs_d[i] = regs_q[i];
            if (addr == 8'(BASE + i)) begin
                hit   = 1'b1;
                rdata = regs_q[i];
                if (wr_en) regs_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LEN; i++) regs_q[i] <= reg_default(8'(BASE + i));
        end else begin
            for (int i = 0; i < LEN; i++) regs_q[i] <= regs_d[i];
        end
    end

    generate
        for (genvar g = 0; g < LEN; g++) begin : g_img
            assign image[g*8 +: 8] = regs_q[g];
        end
    endgenerate
endmodule

// File: rtl/twi_protocol.sv
module twi_protocol
    import twi_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h47
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] reg_addr,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    proto_s c_q, n_d;

    always_comb begin
        n_d   = c_q;
        wr_en = 1'b0;
        if (start_det) begin
            n_d.st   = PS_ADDR;
            n_d.bits = '0;
            n_d.oe   = 1'b0;
        end else if (stop_det) begin
            n_d.st = PS_IDLE;
            n_d.oe = 1'b0;
        end else begin
            case (c_q.st)
                PS_ADDR, PS_REG, PS_WDAT: begin
                    if (scl_rise && c_q.bits != BYTE_BITS) begin
                        n_d.sh   = {c_q.sh[6:0], sda_s};
                        n_d.bits = c_q.bits + 4'd1;
                    end else if (scl_fall && c_q.bits == BYTE_BITS) begin
                        n_d.bits = '0;
                        n_d.st   = PS_SACK;
                        n_d.oe   = 1'b1;
                        if (c_q.st == PS_ADDR) begin
                            if (c_q.sh[7:1] == DEV_ADDR) begin
                                n_d.nxt = c_q.sh[0] ? PS_RDAT : PS_REG;
                            end else begin
                                n_d.st = PS_WAIT;
                                n_d.oe = 1'b0;
                            end
                        end else if (c_q.st == PS_REG) begin
                            n_d.ptr = c_q.sh;
                            n_d.nxt = PS_WDAT;
                        end else begin
                            wr_en   = 1'b1;
                            n_d.ptr = c_q.ptr + 8'd1;
                            n_d.nxt = PS_WDAT;
                        end
                    end
                end
                PS_SACK: begin
                    if (scl_fall) begin
                        n_d.bits = '0;
                        if (c_q.nxt == PS_RDAT) begin
                            n_d.sh  = rd_data;
                            n_d.ptr = c_q.ptr + 8'd1;
                            n_d.oe  = ~rd_data[7];
                            n_d.st  = PS_RDAT;
                        end else begin
                            n_d.oe = 1'b0;
                            n_d.st = c_q.nxt;
                        end
                    end
                end
                PS_RDAT: begin
                    if (scl_fall) begin
                        n_d.bits = c_q.bits + 4'd1;
                        n_d.sh   = {c_q.sh[6:0], 1'b1};
                        if (c_q.bits == BYTE_BITS - 4'd1) begin
                            n_d.oe = 1'b0;
                            n_d.st = PS_MACK;
                        end else begin
                            n_d.oe = ~c_q.sh[6];
                        end
                    end
                end
                PS_MACK: begin
                    if (scl_rise) n_d.macked = ~sda_s;
                    if (scl_fall) begin
                        n_d.bits = '0;
                        if (c_q.macked) begin
                            n_d.sh  = rd_data;
                            n_d.ptr = c_q.ptr + 8'd1;
                            n_d.oe  = ~rd_data[7];
                            n_d.st  = PS_RDAT;
                        end else begin
                            n_d.oe = 1'b0;
                            n_d.st = PS_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: PS_IDLE, nxt: PS_IDLE, bits: 4'd0, sh: 8'h00,
                     ptr: 8'h00, macked: 1'b0, oe: 1'b0};
        end else begin
            c_q <= n_d;
        end
    end

    assign reg_addr = c_q.ptr;
    assign wr_data  = c_q.sh;
    assign sda_oe   = c_q.oe;
endmodule

// File: rtl/twi_cfg_target.sv
module twi_cfg_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h47,
    parameter int         SYNC_STAGES = 2,
    parameter int         A_BASE      = 10,
    parameter int         A_LEN       = 14,
    parameter int         B_BASE      = 64,
    parameter int         B_LEN       = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    output logic [A_LEN*8-1:0] win_a_o,
    output logic [B_LEN*8-1:0] win_b_o
);
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] reg_addr, wr_data, rd_data, a_rd, b_rd;
    logic       wr_en, a_hit, b_hit;

    twi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_protocol #(.DEV_ADDR(DEV_ADDR)) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .reg_addr  (reg_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o)
    );

    twi_reg_window #(.BASE(A_BASE), .LEN(A_LEN)) u_win_a (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (reg_addr),
        .wdata (wr_data),
        .hit   (a_hit),
        .rdata (a_rd),
        .image (win_a_o)
    );

    twi_reg_window #(.BASE(B_BASE), .LEN(B_LEN)) u_win_b (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (reg_addr),
        .wdata (wr_data),
        .hit   (b_hit),
        .rdata (b_rd),
        .image (win_b_o)
    );

    // unbacked addresses read as zero
    assign rd_data = a_hit ? a_rd : (b_hit ? b_rd : 8'h00);
endmodule

// File: rtl/twi_cfg_target_chk.sv
module twi_cfg_target_chk #(
    parameter int A_BASE = 10,
    parameter int A_LEN  = 14,
    parameter int B_BASE = 64,
    parameter int B_LEN  = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       stop_det,
    input logic       wr_en,
    input logic [7:0] reg_addr,
    input logic [7:0] rd_data,
    input logic [7:0] wr_data,
    input logic [7:0] win_a_lo
);
    logic in_a, in_b;
    assign in_a = ({1'b0, reg_addr} >= 9'(A_BASE)) && ({1'b0, reg_addr} < 9'(A_BASE + A_LEN));
    assign in_b = ({1'b0, reg_addr} >= 9'(B_BASE)) && ({1'b0, reg_addr} < 9'(B_BASE + B_LEN));

    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

    p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    p_unbacked_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_a && !in_b) |-> (rd_data == 8'h00));

    p_write_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (reg_addr == 8'($past(reg_addr) + 8'd1)));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 8'hFF) |=> (reg_addr == 8'h00));

    p_image_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 8'(A_BASE)) |=> (win_a_lo == $past(wr_data)));
endmodule

bind twi_cfg_target twi_cfg_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .stop_det (stop_det),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .rd_data  (rd_data),
    .wr_data  (wr_data),
    .win_a_lo (win_a_o[7:0])
);

// File: tb/twi_cfg_target_tb.sv
`timescale 1ns/1ps
module twi_cfg_target_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_bus;
    logic         sda_oe_o;
    logic [111:0] win_a_o;
    logic [191:0] win_b_o;
    int           n_chk = 0;
    int           n_err = 0;
    logic         done = 1'b0;

    always #4 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe_o;

    twi_cfg_target u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe_o),
        .win_a_o  (win_a_o),
        .win_b_o  (win_b_o)
    );

    localparam logic [7:0] WR_ID = 8'h8E;
    localparam logic [7:0] RD_ID = 8'h8F;

    // {register, data written, value expected on read-back}
    localparam logic [23:0] VEC [8] = '{
        {8'h0A, 8'h5A, 8'h5A}, {8'h0F, 8'hC3, 8'hC3},
        {8'h40, 8'h11, 8'h11}, {8'h57, 8'hEE, 8'hEE},
        {8'h20, 8'h77, 8'h00}, {8'hFF, 8'h12, 8'h00},
        {8'h3F, 8'h99, 8'h00}, {8'h58, 8'h44, 8'h00}
    };

    function automatic logic [7:0] img_a(input int i);
        return win_a_o[i*8 +: 8];
    endfunction
    function automatic logic [7:0] img_b(input int i);
        return win_b_o[i*8 +: 8];
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic qtr();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qtr(); scl_m = 1'b1; qtr(); sda_m = 1'b0; qtr(); scl_m = 1'b0; qtr();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qtr(); scl_m = 1'b1; qtr(); sda_m = 1'b1; qtr();
    endtask

    task automatic xfer_bit(input logic b, output logic r);
        sda_m = b; qtr(); scl_m = 1'b1; qtr(); r = sda_bus; qtr(); scl_m = 1'b0; qtr();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) xfer_bit(d[i], r);
        xfer_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic r;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            xfer_bit(1'b1, r);
            d = {d[6:0], r};
        end
        xfer_bit(~give_ack, r);
    endtask

    task automatic wr1(input logic [7:0] ra, input logic [7:0] d, output logic ok);
        logic a0, a1, a2;
        bus_start(); send_byte(WR_ID, a0); send_byte(ra, a1); send_byte(d, a2); bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic rd_rand(input logic [7:0] ra, output logic [7:0] d);
        logic a;
        bus_start(); send_byte(WR_ID, a); send_byte(ra, a);
        bus_start(); send_byte(RD_ID, a); recv_byte(1'b0, d); bus_stop();
    endtask

    task automatic rd_cur(output logic [7:0] d);
        logic a;
        bus_start(); send_byte(RD_ID, a); recv_byte(1'b0, d); bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic       ok, a;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9: reset defaults
        check("R9 reg16", img_a(12), 8'h88);
        check("R9 reg17", img_a(13), 8'h5F);
        check("R9 reg41", img_b(1), 8'hBF);
        check("R9 reg43", img_b(3), 8'hA0);
        check("R9 reg0A", img_a(0), 8'h00);
        check("R7 sda idle", {7'd0, sda_oe_o}, 8'h00);

        // vector walk: single-byte write then random read-back
        for (int v = 0; v < 8; v++) begin
            wr1(VEC[v][23:16], VEC[v][15:8], ok);
            check("R2 write acks", {7'd0, ok}, 8'h01);
            rd_rand(VEC[v][23:16], d);
            if (VEC[v][7:0] == 8'h00) check("R8 unbacked read", d, VEC[v][7:0]);
            else                      check("R3 stored byte", d, VEC[v][7:0]);
        end

        // R10: image buses follow stored bytes
        check("R10 image 0A", img_a(0), 8'h5A);
        check("R10 image 0F", img_a(5), 8'hC3);
        check("R10 image 57", img_b(23), 8'hEE);

        // R1: other device address ignored
        bus_start(); send_byte(8'h46, a);
        check("R1 no ack", {7'd0, a}, 8'h00);
        send_byte(8'h0A, a); send_byte(8'h00, a); bus_stop();
        check("R1 no store", img_a(0), 8'h5A);

        // R3: multi-byte burst, last byte falls off the window
        bus_start(); send_byte(WR_ID, a); send_byte(8'h55, a);
        send_byte(8'h21, a); send_byte(8'h22, a); send_byte(8'h23, a); send_byte(8'h24, a);
        check("R8 unbacked write ack", {7'd0, a}, 8'h01);
        bus_stop();
        check("R3 burst 55", img_b(21), 8'h21);
        check("R3 burst 56", img_b(22), 8'h22);
        check("R3 burst 57", img_b(23), 8'h23);

        // R5: current-address reads
        wr1(8'h15, 8'h3C, ok);
        rd_cur(d);
        check("R5 current after write", d, 8'h88);
        rd_cur(d);
        check("R5 current after read", d, 8'h5F);

        // R6: pointer set, repeated start, no data stored
        rd_rand(8'h0F, d);
        check("R6 read at pointer", d, 8'hC3);
        check("R6 nothing stored", img_a(5), 8'hC3);

        // R7: sequential read across 40h..43h
        bus_start(); send_byte(WR_ID, a); send_byte(8'h40, a);
        bus_start(); send_byte(RD_ID, a);
        recv_byte(1'b1, d); check("R7 seq 40", d, 8'h11);
        recv_byte(1'b1, d); check("R7 seq 41", d, 8'hBF);
        recv_byte(1'b1, d); check("R7 seq 42", d, 8'h00);
        recv_byte(1'b0, d); check("R7 seq 43", d, 8'hA0);
        bus_stop();
        repeat (4) @(negedge clk);
        check("R7 released", {7'd0, sda_oe_o}, 8'h00);

        // R4: wrap FFh -> 00h, run into 0Ah
        bus_start(); send_byte(WR_ID, a); send_byte(8'hFF, a);
        bus_start(); send_byte(RD_ID, a);
        for (int k = 0; k < 11; k++) begin
            recv_byte(1'b1, d);
            if (k == 1) check("R4 byte at 00", d, 8'h00);
        end
        recv_byte(1'b0, d);
        bus_stop();
        check("R4 wrap reaches 0A", d, 8'h5A);

        // R9: reset restores defaults
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 after reset 0A", img_a(0), 8'h00);
        check("R9 after reset 17", img_a(13), 8'h5F);
        check("R9 after reset 57", img_b(23), 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule